// File: doc/BRIEF.md
# Multi-Cycle Operand Transfer Controller

This controller sits between a register file with few ports and a reconfigurable array that runs custom instructions. A custom instruction can name more source operands than the file has read ports, and more results than it has write ports. The controller spreads the reads over as many cycles as needed and gathers the operands into one input vector for the array. It holds that vector while the array runs for one or two cycles, captures the array's results, and then commits them over the write ports in as many cycles as needed. The register file itself is a simple storage model inside the block.

The pipeline starts an operation with a one-cycle request that carries the source and destination register numbers, the operand and result counts, and the execute length. It sees a stall that lasts for the whole operation, and a done pulse in the final write cycle. A parameter selects one of two port layouts: a narrow one with four read and two write ports, and a wide one with eight read and four write ports. Outside an operation, the pipeline's own single write port and single read port reach the same storage.

Top module: `otc_xfer`

## Requirements
- R1: `CFG`=0 gives 4 read ports and 2 write ports. `CFG`=1 gives 8 read ports and 4 write ports.
- R2: The read phase lasts ceil(n_in / read ports) cycles, and at least 1. With CFG 0, 0 to 4 inputs take 1 cycle and 5 to 8 inputs take 2 cycles. With CFG 1, any count takes 1 cycle.
- R3: The write phase lasts ceil(n_out / write ports) cycles, and at least 1. With CFG 0, 0 to 2 results take 1 cycle, 3 to 4 take 2 and 5 to 6 take 3. With CFG 1, 0 to 4 results take 1 cycle and 5 to 6 take 2.
- R4: The execute phase, during which `array_run` is high, lasts 2 cycles when `two_cyc`=1 and 1 cycle otherwise.
- R5: `stall` rises in the cycle after a request is accepted. It stays high for exactly read + execute + write cycles. `done` is high exactly once, in the last of those cycles.
- R6: While `array_run` is high, slot i of `array_in` (bits i*DW and up) holds the register named by field i of `src_regs` (bits i*AW and up) if i < n_in, and zero otherwise. The vector holds steady through the execute phase.
- R7: Slot k of `array_res` is sampled in the last execute cycle. For each k < n_out, in ascending order, that value is written to the register named by field k of `dst_regs`. If two results name the same register, the higher k wins.
- R8: Writes that target register 0 are discarded, and register 0 always reads zero.
- R9: A request raised while `stall` is high is ignored and does not change the timing of the operation in progress.
- R10: A pipeline write (`ext_we`) takes effect only while the controller is idle. A pipeline write in the same cycle as an accepted request is seen by that request's reads.
- R11: After reset, all registers read zero and `stall`, `done` and `array_run` are low.
- R12: An `in_cnt` above 8 is treated as 8, and an `out_cnt` of 7 is treated as 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted only when idle |
| in_cnt | input | 4 | Number of source operands |
| out_cnt | input | 3 | Number of results |
| two_cyc | input | 1 | Execute phase takes two cycles |
| src_regs | input | 8*AW | Source register numbers, field i at bits i*AW |
| dst_regs | input | 6*AW | Destination register numbers, field k at bits k*AW |
| ext_we | input | 1 | Pipeline write enable |
| ext_waddr | input | AW | Pipeline write register |
| ext_wdata | input | DW | Pipeline write data |
| ext_raddr | input | AW | Pipeline read register |
| ext_rdata | output | DW | Pipeline read data |
| array_in | output | 8*DW | Operand vector to the array |
| array_run | output | 1 | Execute phase active |
| array_res | input | 6*DW | Result vector from the array |
| stall | output | 1 | Operation in progress |
| done | output | 1 | Final write cycle |

## Verification
Two events can land in the same clock edge: a pipeline write and the acceptance of a request whose first operand reads that same register. The bench raises both strobes on one edge and then checks that slot 0 of the input vector carries the newly written value, not the old one. A second overlap is two results that name the same destination within one write cycle. The bench provokes it with destination patterns that repeat numbers across slots, and judges it by reading back each register through the pipeline read port and comparing against a model that applies the writes in ascending order.

// File: rtl/otc_pkg.sv
package otc_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_READ  = 2'd1,
      PH_EXEC  = 2'd2,
      PH_WRITE = 2'd3
   } phase_t;

   // port layout chosen by the configuration parameter
   function automatic int rd_ports(int cfg);
      return (cfg == 0) ? 4 : 8;
   endfunction

   function automatic int wr_ports(int cfg);
      return (cfg == 0) ? 2 : 4;
   endfunction

endpackage

// File: rtl/otc_regfile.sv
module otc_regfile #(
   parameter int DW   = 32,
   parameter int NREG = 32,
   parameter int RP   = 4,
   parameter int WP   = 2,
   localparam int AW  = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [RP*AW-1:0]   rd_addr,
   output logic [RP*DW-1:0]   rd_data,
   input  logic [WP-1:0]      wr_en,
   input  logic [WP*AW-1:0]   wr_addr,
   input  logic [WP*DW-1:0]   wr_data,
   input  logic               ext_en,
   input  logic [AW-1:0]      ext_addr,
   input  logic [DW-1:0]      ext_data,
   input  logic [AW-1:0]      ext_raddr,
   output logic [DW-1:0]      ext_rdata
);

   logic [DW-1:0] mem [NREG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < NREG; r++) mem[r] <= '0;
      end else begin
         if (ext_en && ext_addr != '0) mem[ext_addr] <= ext_data;
         // ascending port order: later port overrides on equal address
         for (int p = 0; p < WP; p++) begin
            if (wr_en[p] && wr_addr[p*AW +: AW] != '0)
               mem[wr_addr[p*AW +: AW]] <= wr_data[p*DW +: DW];
         end
      end
   end

   for (genvar p = 0; p < RP; p++) begin : g_rd
      assign rd_data[p*DW +: DW] = mem[rd_addr[p*AW +: AW]];
   end

   assign ext_rdata = mem[ext_raddr];

   // the controller must already filter register-0 targets
   logic zero_hit;
   always_comb begin
      zero_hit = 1'b0;
      for (int p = 0; p < WP; p++)
         if (wr_en[p] && wr_addr[p*AW +: AW] == '0) zero_hit = 1'b1;
   end

   assert_no_zero_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !zero_hit);

   assert_ext_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ext_en |-> (wr_en == '0));

endmodule

// File: rtl/otc_seq.sv
module otc_seq
   import otc_pkg::*;
#(
   parameter int RP = 4,
   parameter int WP = 2,
   parameter int IW = 4,
   parameter int OW = 3,
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [IW-1:0] n_in,
   input  logic [OW-1:0] n_out,
   input  logic          two_cyc,
   output phase_t        phase,
   output logic [CW-1:0] step,
   output logic          accept,
   output logic          last_exec,
   output logic          done,
   output logic          stall
);

   logic [CW-1:0] rd_tot, wr_tot, ex_tot;
   logic [CW-1:0] rd_need, wr_need;

   assign rd_need = (n_in  == '0) ? CW'(1) : CW'((int'(n_in)  + RP - 1) / RP);
   assign wr_need = (n_out == '0) ? CW'(1) : CW'((int'(n_out) + WP - 1) / WP);

   assign accept    = start && (phase == PH_IDLE);
   assign last_exec = (phase == PH_EXEC)  && (step == ex_tot - CW'(1));
   assign done      = (phase == PH_WRITE) && (step == wr_tot - CW'(1));
   assign stall     = (phase != PH_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         step   <= '0;
         rd_tot <= '0;
         wr_tot <= '0;
         ex_tot <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: if (accept) begin
               rd_tot <= rd_need;
               wr_tot <= wr_need;
               ex_tot <= two_cyc ? CW'(2) : CW'(1);
               step   <= '0;
               phase  <= PH_READ;
            end
            PH_READ: begin
               if (step == rd_tot - CW'(1)) begin
                  step  <= '0;
                  phase <= PH_EXEC;
               end else step <= step + CW'(1);
            end
            PH_EXEC: begin
               if (last_exec) begin
                  step  <= '0;
                  phase <= PH_WRITE;
               end else step <= step + CW'(1);
            end
            PH_WRITE: begin
               if (done) begin
                  step  <= '0;
                  phase <= PH_IDLE;
               end else step <= step + CW'(1);
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assert_totals_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE) |=> ($stable(rd_tot) && $stable(wr_tot) && $stable(ex_tot)));

   assert_done_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (phase == PH_IDLE));

   assert_exec_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_EXEC) |-> (ex_tot == CW'(1) || ex_tot == CW'(2)));

   assert_read_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_READ) |-> (step < rd_tot));

endmodule

// File: rtl/otc_xfer.sv
module otc_xfer
   import otc_pkg::*;
#(
   parameter int CFG     = 0,
   parameter int DW      = 32,
   parameter int NREG    = 32,
   parameter int MAX_IN  = 8,
   parameter int MAX_OUT = 6,
   localparam int AW     = $clog2(NREG),
   localparam int IW     = $clog2(MAX_IN + 1),
   localparam int OW     = $clog2(MAX_OUT + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [IW-1:0]         in_cnt,
   input  logic [OW-1:0]         out_cnt,
   input  logic                  two_cyc,
   input  logic [MAX_IN*AW-1:0]  src_regs,
   input  logic [MAX_OUT*AW-1:0] dst_regs,
   input  logic                  ext_we,
   input  logic [AW-1:0]         ext_waddr,
   input  logic [DW-1:0]         ext_wdata,
   input  logic [AW-1:0]         ext_raddr,
   output logic [DW-1:0]         ext_rdata,
   output logic [MAX_IN*DW-1:0]  array_in,
   output logic                  array_run,
   input  logic [MAX_OUT*DW-1:0] array_res,
   output logic                  stall,
   output logic                  done
);

   localparam int RP = rd_ports(CFG);
   localparam int WP = wr_ports(CFG);
   localparam int CW = $clog2(MAX_IN + MAX_OUT + 3);

   if (CFG != 0 && CFG != 1) begin : g_bad_cfg
      $error("otc_xfer: CFG must be 0 or 1");
   end
   if (NREG != (1 << AW) || NREG < 2) begin : g_bad_nreg
      $error("otc_xfer: NREG must be a power of two, at least 2");
   end
   if (MAX_IN < 1 || MAX_OUT < 1 || DW < 1) begin : g_bad_size
      $error("otc_xfer: operand and result counts and width must be positive");
   end

   // request fields clamped to the vector sizes
   logic [IW-1:0] in_cl;
   logic [OW-1:0] out_cl;
   assign in_cl  = (int'(in_cnt)  > MAX_IN)  ? IW'(MAX_IN)  : in_cnt;
   assign out_cl = (int'(out_cnt) > MAX_OUT) ? OW'(MAX_OUT) : out_cnt;

   phase_t        phase;
   logic [CW-1:0] step;
   logic          accept, last_exec;

   otc_seq #(.RP(RP), .WP(WP), .IW(IW), .OW(OW), .CW(CW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .n_in(in_cl), .n_out(out_cl), .two_cyc(two_cyc),
      .phase(phase), .step(step), .accept(accept),
      .last_exec(last_exec), .done(done), .stall(stall)
   );

   logic [MAX_IN*AW-1:0]  src_q;
   logic [MAX_OUT*AW-1:0] dst_q;
   logic [IW-1:0]         in_q;
   logic [OW-1:0]         out_q;
   logic [MAX_IN*DW-1:0]  vec_q;
   logic [MAX_OUT*DW-1:0] res_q;

   logic [RP*AW-1:0] rd_addr;
   logic [RP*DW-1:0] rd_data;
   logic [WP-1:0]    wr_en;
   logic [WP*AW-1:0] wr_addr;
   logic [WP*DW-1:0] wr_data;
   logic             ext_en;

   assign ext_en = ext_we && (phase == PH_IDLE);

   otc_regfile #(.DW(DW), .NREG(NREG), .RP(RP), .WP(WP)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ext_en(ext_en), .ext_addr(ext_waddr), .ext_data(ext_wdata),
      .ext_raddr(ext_raddr), .ext_rdata(ext_rdata)
   );

   // read slots for this step: operand index = step*RP + port
   always_comb begin
      rd_addr = '0;
      for (int p = 0; p < RP; p++) begin
         if (int'(step) * RP + p < MAX_IN)
            rd_addr[p*AW +: AW] = src_q[(int'(step) * RP + p) * AW +: AW];
      end
   end

   // write slots for this step: result index = step*WP + port
   always_comb begin
      wr_en   = '0;
      wr_addr = '0;
      wr_data = '0;
      for (int p = 0; p < WP; p++) begin
         if (phase == PH_WRITE && int'(step) * WP + p < int'(out_q)) begin
            wr_addr[p*AW +: AW] = dst_q[(int'(step) * WP + p) * AW +: AW];
            wr_data[p*DW +: DW] = res_q[(int'(step) * WP + p) * DW +: DW];
            wr_en[p] = (dst_q[(int'(step) * WP + p) * AW +: AW] != '0);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q <= '0;
         dst_q <= '0;
         in_q  <= '0;
         out_q <= '0;
         vec_q <= '0;
         res_q <= '0;
      end else begin
         if (accept) begin
            src_q <= src_regs;
            dst_q <= dst_regs;
            in_q  <= in_cl;
            out_q <= out_cl;
            vec_q <= '0;
         end else if (phase == PH_READ) begin
            for (int p = 0; p < RP; p++) begin
               if (int'(step) * RP + p < int'(in_q))
                  vec_q[(int'(step) * RP + p) * DW +: DW] <= rd_data[p*DW +: DW];
            end
         end
         if (last_exec) res_q <= array_res;
      end
   end

   assign array_in  = vec_q;
   assign array_run = (phase == PH_EXEC);

   assert_vec_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      array_run |=> $stable(array_in));

   assert_run_in_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      array_run |-> (stall && !done));

   assert_writes_only_late_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en != '0) |-> stall);

   assert_accept_raises_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (stall && !array_run));

endmodule

// File: tb/otc_xfer_test.sv
module otc_xfer_test;

   localparam int DW = 16, NREG = 32, AW = 5, MI = 8, MO = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [3:0]       in_cnt = '0;
   logic [2:0]       out_cnt = '0;
   logic             two_cyc = 1'b0;
   logic [MI*AW-1:0] src = '0;
   logic [MO*AW-1:0] dst = '0;
   logic [AW-1:0]    waddr = '0, raddr = '0;
   logic [DW-1:0]    wdata = '0;
   logic [MO*DW-1:0] res = '0;
   logic             start_a = 1'b0, start_b = 1'b0, we_a = 1'b0, we_b = 1'b0;
   logic [DW-1:0]    rd_a, rd_b;
   logic [MI*DW-1:0] vin_a, vin_b;
   logic             run_a, run_b, stall_a, stall_b, done_a, done_b;

   otc_xfer #(.CFG(0), .DW(DW), .NREG(NREG)) uut (
      .clk(clk), .rst_n(rst_n), .start(start_a), .in_cnt(in_cnt), .out_cnt(out_cnt),
      .two_cyc(two_cyc), .src_regs(src), .dst_regs(dst), .ext_we(we_a),
      .ext_waddr(waddr), .ext_wdata(wdata), .ext_raddr(raddr), .ext_rdata(rd_a),
      .array_in(vin_a), .array_run(run_a), .array_res(res), .stall(stall_a), .done(done_a));

   otc_xfer #(.CFG(1), .DW(DW), .NREG(NREG)) uut_b (
      .clk(clk), .rst_n(rst_n), .start(start_b), .in_cnt(in_cnt), .out_cnt(out_cnt),
      .two_cyc(two_cyc), .src_regs(src), .dst_regs(dst), .ext_we(we_b),
      .ext_waddr(waddr), .ext_wdata(wdata), .ext_raddr(raddr), .ext_rdata(rd_b),
      .array_in(vin_b), .array_run(run_b), .array_res(res), .stall(stall_b), .done(done_b));

   logic [DW-1:0] mdl [2][NREG];
   int checks = 0, errors = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int need(input int n, input int p);
      return (n == 0) ? 1 : (n + p - 1) / p;
   endfunction

   task automatic rd_reg(input int sel, input int a, output int v);
      raddr = AW'(a);
      #1;
      v = sel ? int'(rd_b) : int'(rd_a);
   endtask

   task automatic ext_write(input int sel, input int a, input int d);
      @(negedge clk);
      waddr = AW'(a); wdata = DW'(d);
      if (sel) we_b = 1'b1; else we_a = 1'b1;
      @(negedge clk);
      we_a = 1'b0; we_b = 1'b0;
      if (a != 0) mdl[sel][a] = DW'(d);
   endtask

   // one operation; wa > 0 adds a pipeline write in the accept cycle
   task automatic run(input int sel, input int ni, input int no, input int tc,
                      input int seed, input int wa, output int total, output int slot0);
      int rp, wp, nie, noe, rc, ec, wc, dcnt, dat, idx, v;
      bit seen, vchk, vok;
      int exp_v [MI];
      rp = sel ? 8 : 4; wp = sel ? 4 : 2;
      nie = (ni > MI) ? MI : ni; noe = (no > MO) ? MO : no;
      @(negedge clk);
      in_cnt = 4'(ni); out_cnt = 3'(no); two_cyc = tc[0];
      for (int i = 0; i < MI; i++) src[i*AW +: AW] = AW'((seed * 5 + i * 3) % NREG);
      for (int k = 0; k < MO; k++) dst[k*AW +: AW] = AW'((seed * 3 + k * k) % 8);
      for (int k = 0; k < MO; k++) res[k*DW +: DW] = DW'(seed * 37 + k * 11 + 1);
      if (wa > 0) begin
         waddr = AW'(wa); wdata = DW'(16'h1234 + seed);
         if (sel) we_b = 1'b1; else we_a = 1'b1;
         mdl[sel][wa] = DW'(16'h1234 + seed);
      end
      if (sel) start_b = 1'b1; else start_a = 1'b1;
      for (int i = 0; i < MI; i++)
         exp_v[i] = (i < nie) ? int'(mdl[sel][int'(src[i*AW +: AW])]) : 0;
      @(negedge clk);
      start_a = 1'b0; start_b = 1'b0; we_a = 1'b0; we_b = 1'b0;
      rc = 0; ec = 0; wc = 0; dcnt = 0; dat = -1; idx = 0; seen = 0; vchk = 0; vok = 1;
      slot0 = -1;
      while ((sel ? stall_b : stall_a) && idx < 40) begin
         idx++;
         if (sel ? run_b : run_a) begin
            ec++; seen = 1;
            if (!vchk) begin
               vchk = 1;
               slot0 = int'(sel ? vin_b[DW-1:0] : vin_a[DW-1:0]);
               for (int i = 0; i < MI; i++) begin
                  v = int'(sel ? vin_b[i*DW +: DW] : vin_a[i*DW +: DW]);
                  if (v != exp_v[i] && vok) begin
                     vok = 0;
                     chk(0, "R6", $sformatf("operand slot %0d", i), v, exp_v[i]);
                  end
               end
            end
         end else if (!seen) rc++;
         else wc++;
         if (sel ? done_b : done_a) begin dcnt++; dat = idx; end
         @(negedge clk);
      end
      total = idx;
      chk(vchk && vok, "R6", "input vector", int'(vchk), 1);
      chk(rc == need(nie, rp), "R1 R2", "read cycles", rc, need(nie, rp));
      chk(ec == (tc ? 2 : 1), "R4", "execute cycles", ec, tc ? 2 : 1);
      chk(wc == need(noe, wp), "R1 R3", "write cycles", wc, need(noe, wp));
      chk(dcnt == 1 && dat == idx, "R5", "done position", dat, idx);
      for (int k = 0; k < noe; k++) begin
         int d;
         d = int'(dst[k*AW +: AW]);
         if (d != 0) mdl[sel][d] = res[k*DW +: DW];
      end
      begin
         bit ok;
         ok = 1;
         for (int r = 0; r < NREG; r++) begin
            rd_reg(sel, r, v);
            if (ok && v != int'(mdl[sel][r])) begin
               ok = 0;
               chk(0, "R7 R8", $sformatf("register %0d", r), v, int'(mdl[sel][r]));
            end
         end
         chk(ok, "R7", "register file after write-back", int'(ok), 1);
      end
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int v, tot, s0;
      for (int s = 0; s < 2; s++) for (int r = 0; r < NREG; r++) mdl[s][r] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(!stall_a && !done_a && !run_a, "R11", "control outputs A", int'(stall_a), 0);
      chk(!stall_b && !done_b && !run_b, "R11", "control outputs B", int'(stall_b), 0);
      rd_reg(0, 7, v);
      chk(v == 0, "R11", "register 7 after reset", v, 0);
      // preload both files; the write to register 0 must be dropped
      for (int s = 0; s < 2; s++)
         for (int r = 0; r < NREG; r++) ext_write(s, r, r * 97 + 3);
      rd_reg(0, 0, v);
      chk(v == 0, "R8", "register 0 after pipeline write", v, 0);
      rd_reg(1, 31, v);
      chk(v == 31 * 97 + 3, "R10", "idle pipeline write", v, 31 * 97 + 3);
      // sweep of counts, execute lengths and both configurations
      for (int s = 0; s < 2; s++)
         for (int ni = 0; ni <= MI; ni++)
            for (int no = 0; no <= MO; no++)
               for (int tc = 0; tc < 2; tc++)
                  run(s, ni, no, tc, ni * 7 + no * 3 + tc + s, 0, tot, s0);
      // R12 clamping of oversize counts
      run(0, 12, 7, 0, 4, 0, tot, s0);
      chk(tot == 6, "R12", "clamped total stall A", tot, 6);
      run(1, 15, 7, 1, 5, 0, tot, s0);
      chk(tot == 5, "R12", "clamped total stall B", tot, 5);
      // R10 pipeline write in the accept cycle is seen by the reads (seed 9 -> src0 = 13)
      run(0, 1, 0, 0, 9, 13, tot, s0);
      chk(s0 == 16'h1234 + 9, "R10", "same-cycle write seen by slot 0", s0, 16'h1234 + 9);
      run(1, 1, 0, 1, 9, 13, tot, s0);
      chk(s0 == 16'h1234 + 9, "R10", "same-cycle write seen by slot 0 B", s0, 16'h1234 + 9);
      // R9 and R10: request and pipeline write raised while busy are ignored
      fork
         run(0, 8, 6, 1, 11, 0, tot, s0);
         begin
            repeat (3) @(negedge clk);
            start_a = 1'b1; we_a = 1'b1; waddr = AW'(29); wdata = 16'hBEEF;
            @(negedge clk);
            start_a = 1'b0; we_a = 1'b0;
         end
      join
      chk(tot == 2 + 2 + 3, "R9", "stall length with busy request", tot, 7);
      @(negedge clk);
      chk(!stall_a, "R9", "no second operation started", int'(stall_a), 0);
      rd_reg(0, 29, v);
      chk(v == int'(mdl[0][29]), "R10", "busy pipeline write dropped", v, int'(mdl[0][29]));
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule